// File: doc/BRIEF.md
# Self-Healing Read Barrier Unit

This block sits beside a processor pipeline and resolves a reference-load barrier in hardware instead of trapping to software. Each request carries a reference value just loaded from memory, the base and offset the value came from, a flag saying the access hit a protected (relocating) page, and a flag saying whether the instruction was a barrier or an ordinary load or store.

Two kinds of repair are made. A reference whose top bit disagrees with the current mark parity has not been passed to the marker yet. It is posted to the marker's mailbox, its top bit is inverted, and the repaired word is written back to its source address. A reference into a relocating page is sent to the relocation service, and the block waits for the new address as long as the service needs. For a barrier, the new address is written back to the source. For an ordinary access, it is returned only as the new register value. When both repairs apply, relocation comes first and the tag check is made on the new address. Each request ends with a one-cycle completion pulse that carries the final register value.

Top module: `rb_heal_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `mbox_valid`, `rel_req_valid`, `wb_valid` and `done_valid` are all 0.
- R2: A barrier with no fault whose reference bit REF_W-1 equals `mark_parity` produces no mailbox post, no relocation request and no writeback, and completes with `done_ref` equal to the input reference.
- R3: A barrier with no fault whose bit REF_W-1 differs from `mark_parity` posts the unmodified reference to the mailbox exactly once.
- R4: For such a stale barrier, exactly one writeback is made after the mailbox post. It goes to address `req_base + req_off` (offset zero-extended) and carries the reference with bit REF_W-1 inverted. `done_ref` carries the same value.
- R5: While `mbox_ready` is 0, `mbox_valid` stays 1, `mbox_data` stays stable and no writeback is issued. No reference is lost.
- R6: A barrier with `req_fault` set issues one relocation request carrying the loaded reference. It waits for `rel_rsp_valid` without a time limit. It then writes the returned address to `req_base + req_off` and completes with that address.
- R7: An ordinary access (`req_barrier` = 0) never causes a mailbox post or a writeback. With `req_fault` set, it still requests relocation and returns the new address on `done_ref`. Without a fault, it returns the input reference.
- R8: When a faulting barrier receives a new address whose bit REF_W-1 differs from the parity, the relocation completes first. The mailbox then receives the new address, and the writeback carries the new address with bit REF_W-1 inverted.
- R9: The tag test uses the `mark_parity` value captured when the request is accepted. The same reference is stale under one parity and clean under the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Barrier/access request present |
| req_ready | output | 1 | Unit idle and accepting a request |
| req_ref | input | REF_W | Reference value as loaded |
| req_base | input | ADDR_W | Base address of the load |
| req_off | input | OFF_W | Offset added to the base |
| req_fault | input | 1 | Access hit a page under relocation |
| req_barrier | input | 1 | 1 for a barrier instruction, 0 for an ordinary access |
| mark_parity | input | 1 | Current mark phase number modulo 2 |
| mbox_valid | output | 1 | Mailbox post pending |
| mbox_ready | input | 1 | Mailbox can take a word |
| mbox_data | output | REF_W | Reference handed to the marker |
| rel_req_valid | output | 1 | One-cycle relocation request |
| rel_req_ref | output | REF_W | Old address sent to the relocation service |
| rel_rsp_valid | input | 1 | Relocation answer present |
| rel_rsp_ref | input | REF_W | New address from the relocation service |
| wb_valid | output | 1 | One-cycle healing store |
| wb_addr | output | ADDR_W | Store address |
| wb_data | output | REF_W | Healed reference |
| done_valid | output | 1 | One-cycle completion |
| done_ref | output | REF_W | Final register value |

## Verification
A wrong captured parity or a wrong stale decision shows at the ports within two cycles of acceptance. The symptom is a mailbox post that should not happen, or one that is missing, or a writeback whose top bit does not match the phase. A lost relocation answer shows as a completion that never arrives. A wrongly ordered repair shows as the mailbox receiving the old address instead of the new one. A broken stall path shows as a writeback, or a change in `mbox_data`, in a cycle where `mbox_ready` is still low.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RREQ  = 3'd1,
    ST_RWAIT = 3'd2,
    ST_CHECK = 3'd3,
    ST_MARK  = 3'd4,
    ST_HEAL  = 3'd5,
    ST_DONE  = 3'd6
  } rb_state_e;
endpackage

// File: rtl/rb_addr_calc.sv
module rb_addr_calc #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD_W = ADDR_W - OFF_W;

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [OFF_W-1:0] o);
    return b + {{PAD_W{1'b0}}, o};
  endfunction

  assign addr = slot_addr(base, off);
endmodule

// File: rtl/rb_tag_check.sv
module rb_tag_check #(
  parameter int REF_W = 32
) (
  input  logic [REF_W-1:0] ref_in,
  input  logic             parity,
  output logic             stale,
  output logic [REF_W-1:0] ref_fixed
);
  localparam int TAG_BIT = REF_W - 1;

  function automatic logic tag_stale(input logic [REF_W-1:0] r, input logic p);
    return r[TAG_BIT] != p;
  endfunction

  function automatic logic [REF_W-1:0] tag_flip(input logic [REF_W-1:0] r);
    logic [REF_W-1:0] t;
    t = r;
    t[TAG_BIT] = ~r[TAG_BIT];
    return t;
  endfunction

  assign stale     = tag_stale(ref_in, parity);
  assign ref_fixed = tag_flip(ref_in);
endmodule

// File: rtl/rb_heal_seq.sv
module rb_heal_seq
  import rb_pkg::*;
#(
  parameter int REF_W  = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [REF_W-1:0]  req_ref,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_fault,
  input  logic              req_barrier,
  input  logic              mark_parity,
  input  logic              stale,
  input  logic [REF_W-1:0]  ref_fixed,
  output logic [REF_W-1:0]  cur_ref,
  output logic              op_parity,
  output logic              op_barrier,
  output logic              mbox_valid,
  input  logic              mbox_ready,
  output logic [REF_W-1:0]  mbox_data,
  output logic              rel_req_valid,
  output logic [REF_W-1:0]  rel_req_ref,
  input  logic              rel_rsp_valid,
  input  logic [REF_W-1:0]  rel_rsp_ref,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [REF_W-1:0]  wb_data,
  output logic              done_valid,
  output logic [REF_W-1:0]  done_ref
);
  rb_state_e         state;
  logic [ADDR_W-1:0] op_addr;
  logic              op_moved;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_ref    <= '0;
      op_addr    <= '0;
      op_parity  <= 1'b0;
      op_barrier <= 1'b0;
      op_moved   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          cur_ref    <= req_ref;
          op_addr    <= req_addr;
          op_parity  <= mark_parity;
          op_barrier <= req_barrier;
          op_moved   <= 1'b0;
          state      <= req_fault ? ST_RREQ : ST_CHECK;
        end
        ST_RREQ:  state <= ST_RWAIT;
        ST_RWAIT: if (rel_rsp_valid) begin
          cur_ref  <= rel_rsp_ref;
          op_moved <= 1'b1;
          state    <= ST_CHECK;
        end
        ST_CHECK: begin
          if (op_barrier && stale)         state <= ST_MARK;
          else if (op_barrier && op_moved) state <= ST_HEAL;
          else                             state <= ST_DONE;
        end
        ST_MARK: if (mbox_ready) begin
          cur_ref <= ref_fixed;
          state   <= ST_HEAL;
        end
        ST_HEAL: state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign mbox_valid    = (state == ST_MARK);
  assign mbox_data     = cur_ref;
  assign rel_req_valid = (state == ST_RREQ);
  assign rel_req_ref   = cur_ref;
  assign wb_valid      = (state == ST_HEAL);
  assign wb_addr       = op_addr;
  assign wb_data       = cur_ref;
  assign done_valid    = (state == ST_DONE);
  assign done_ref      = cur_ref;
endmodule

// File: rtl/rb_heal_unit.sv
module rb_heal_unit #(
  parameter int REF_W  = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [REF_W-1:0]  req_ref,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_off,
  input  logic              req_fault,
  input  logic              req_barrier,
  input  logic              mark_parity,
  output logic              mbox_valid,
  input  logic              mbox_ready,
  output logic [REF_W-1:0]  mbox_data,
  output logic              rel_req_valid,
  output logic [REF_W-1:0]  rel_req_ref,
  input  logic              rel_rsp_valid,
  input  logic [REF_W-1:0]  rel_rsp_ref,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [REF_W-1:0]  wb_data,
  output logic              done_valid,
  output logic [REF_W-1:0]  done_ref
);
  logic [ADDR_W-1:0] slot_addr;
  logic [REF_W-1:0]  cur_ref;
  logic [REF_W-1:0]  ref_fixed;
  logic              stale;
  logic              op_parity;
  logic              op_barrier;

  rb_addr_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .base (req_base),
    .off  (req_off),
    .addr (slot_addr)
  );

  rb_tag_check #(.REF_W(REF_W)) u_tag (
    .ref_in    (cur_ref),
    .parity    (op_parity),
    .stale     (stale),
    .ref_fixed (ref_fixed)
  );

  rb_heal_seq #(.REF_W(REF_W), .ADDR_W(ADDR_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_ref       (req_ref),
    .req_addr      (slot_addr),
    .req_fault     (req_fault),
    .req_barrier   (req_barrier),
    .mark_parity   (mark_parity),
    .stale         (stale),
    .ref_fixed     (ref_fixed),
    .cur_ref       (cur_ref),
    .op_parity     (op_parity),
    .op_barrier    (op_barrier),
    .mbox_valid    (mbox_valid),
    .mbox_ready    (mbox_ready),
    .mbox_data     (mbox_data),
    .rel_req_valid (rel_req_valid),
    .rel_req_ref   (rel_req_ref),
    .rel_rsp_valid (rel_rsp_valid),
    .rel_rsp_ref   (rel_rsp_ref),
    .wb_valid      (wb_valid),
    .wb_addr       (wb_addr),
    .wb_data       (wb_data),
    .done_valid    (done_valid),
    .done_ref      (done_ref)
  );
endmodule

// File: rtl/rb_heal_chk.sv
module rb_heal_chk #(
  parameter int REF_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             mbox_valid,
  input logic             mbox_ready,
  input logic [REF_W-1:0] mbox_data,
  input logic             rel_req_valid,
  input logic             wb_valid,
  input logic [REF_W-1:0] wb_data,
  input logic             done_valid,
  input logic             op_parity,
  input logic             op_barrier
);
  AST_MBOX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_valid && !mbox_ready) |=> (mbox_valid && $stable(mbox_data) && !wb_valid)); // R5

  AST_WB_TAG_OK: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_data[REF_W-1] == op_parity)); // R4

  AST_NONBAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_barrier |-> (!wb_valid && !mbox_valid)); // R7

  AST_RELOC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    rel_req_valid |=> (!mbox_valid && !wb_valid)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && req_ready)); // R2
endmodule

bind rb_heal_unit rb_heal_chk #(.REF_W(REF_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mbox_valid    (mbox_valid),
  .mbox_ready    (mbox_ready),
  .mbox_data     (mbox_data),
  .rel_req_valid (rel_req_valid),
  .wb_valid      (wb_valid),
  .wb_data       (wb_data),
  .done_valid    (done_valid),
  .op_parity     (op_parity),
  .op_barrier    (op_barrier)
);

// File: tb/rb_heal_unit_tb.sv
module rb_heal_unit_tb;
  localparam int REF_W  = 32;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [REF_W-1:0]  req_ref = '0;
  logic [ADDR_W-1:0] req_base = '0;
  logic [OFF_W-1:0]  req_off = '0;
  logic              req_fault = 1'b0;
  logic              req_barrier = 1'b0;
  logic              mark_parity = 1'b0;
  logic              mbox_valid;
  logic              mbox_ready = 1'b1;
  logic [REF_W-1:0]  mbox_data;
  logic              rel_req_valid;
  logic [REF_W-1:0]  rel_req_ref;
  logic              rel_rsp_valid = 1'b0;
  logic [REF_W-1:0]  rel_rsp_ref = '0;
  logic              wb_valid;
  logic [ADDR_W-1:0] wb_addr;
  logic [REF_W-1:0]  wb_data;
  logic              done_valid;
  logic [REF_W-1:0]  done_ref;

  int n_tests = 0;
  int n_fail  = 0;

  int                n_mbox, n_wb, n_rel, n_done;
  logic [REF_W-1:0]  got_mbox, got_wb, got_rel, got_done;
  logic [ADDR_W-1:0] got_wb_addr;
  int                rsp_delay = 0;
  logic [REF_W-1:0]  rsp_value = '0;

  always #10 clk = ~clk;

  rb_heal_unit #(.REF_W(REF_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ref(req_ref), .req_base(req_base), .req_off(req_off),
    .req_fault(req_fault), .req_barrier(req_barrier), .mark_parity(mark_parity),
    .mbox_valid(mbox_valid), .mbox_ready(mbox_ready), .mbox_data(mbox_data),
    .rel_req_valid(rel_req_valid), .rel_req_ref(rel_req_ref),
    .rel_rsp_valid(rel_rsp_valid), .rel_rsp_ref(rel_rsp_ref),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .done_valid(done_valid), .done_ref(done_ref)
  );

  // Port monitor, sampled mid-cycle.
  always @(negedge clk) begin
    if (mbox_valid && mbox_ready) begin n_mbox++; got_mbox = mbox_data; end
    if (wb_valid) begin n_wb++; got_wb = wb_data; got_wb_addr = wb_addr; end
    if (rel_req_valid) begin n_rel++; got_rel = rel_req_ref; end
    if (done_valid) begin n_done++; got_done = done_ref; end
  end

  // Relocation service model with programmable latency.
  initial begin
    forever begin
      @(negedge clk);
      if (rel_req_valid) begin
        repeat (rsp_delay) @(posedge clk);
        @(posedge clk);
        #1 rel_rsp_valid = 1'b1; rel_rsp_ref = rsp_value;
        @(posedge clk);
        #1 rel_rsp_valid = 1'b0;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    n_mbox = 0; n_wb = 0; n_rel = 0; n_done = 0;
    got_mbox = '0; got_wb = '0; got_rel = '0; got_done = '0; got_wb_addr = '0;
  endtask

  task automatic issue(input logic [REF_W-1:0] r, input logic [ADDR_W-1:0] b,
                       input logic [OFF_W-1:0] o, input logic flt, input logic bar,
                       input logic par);
    clear_counts();
    @(posedge clk);
    #1;
    req_valid = 1'b1; req_ref = r; req_base = b; req_off = o;
    req_fault = flt; req_barrier = bar; mark_parity = par;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int k;
    k = 0;
    while (n_done == 0 && k < 500) begin @(negedge clk); k++; end
    @(negedge clk);
    check({req, " completion"}, 64'(n_done), 64'd1);
  endtask

  task automatic t_reset();
    check("R1 req_ready", 64'(req_ready), 64'd1);
    check("R1 mbox_valid", 64'(mbox_valid), 64'd0);
    check("R1 rel_req_valid", 64'(rel_req_valid), 64'd0);
    check("R1 wb_valid", 64'(wb_valid), 64'd0);
    check("R1 done_valid", 64'(done_valid), 64'd0);
  endtask

  task automatic t_clean(input logic par, input logic [REF_W-1:0] r);
    issue(r, 32'h1000_0000, 12'h010, 1'b0, 1'b1, par);
    wait_done("R2");
    check("R2 no mailbox", 64'(n_mbox), 64'd0);
    check("R2 no writeback", 64'(n_wb), 64'd0);
    check("R2 no relocation", 64'(n_rel), 64'd0);
    check("R2 done value", 64'(got_done), 64'(r));
  endtask

  task automatic t_stale(input string tag, input logic par, input logic [REF_W-1:0] r);
    logic [REF_W-1:0] fixed;
    fixed = {~r[REF_W-1], r[REF_W-2:0]};
    issue(r, 32'h2000_0100, 12'h024, 1'b0, 1'b1, par);
    wait_done(tag);
    check({tag, " R3 mailbox count"}, 64'(n_mbox), 64'd1);
    check({tag, " R3 mailbox data"}, 64'(got_mbox), 64'(r));
    check({tag, " R4 writeback count"}, 64'(n_wb), 64'd1);
    check({tag, " R4 writeback addr"}, 64'(got_wb_addr), 64'h2000_0124);
    check({tag, " R4 writeback data"}, 64'(got_wb), 64'(fixed));
    check({tag, " R4 done value"}, 64'(got_done), 64'(fixed));
  endtask

  task automatic t_stall();
    int k;
    mbox_ready = 1'b0;
    issue(32'h0000_7700, 32'h3000_0000, 12'h008, 1'b0, 1'b1, 1'b1);
    k = 0;
    while (!mbox_valid && k < 50) begin @(negedge clk); k++; end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R5 mailbox held", 64'(mbox_valid), 64'd1);
      check("R5 mailbox data stable", 64'(mbox_data), 64'h0000_7700);
      check("R5 no writeback while blocked", 64'(n_wb), 64'd0);
    end
    @(posedge clk);
    #1 mbox_ready = 1'b1;
    wait_done("R5");
    check("R5 one post after release", 64'(n_mbox), 64'd1);
    check("R5 writeback after release", 64'(got_wb), 64'h8000_7700);
  endtask

  task automatic t_reloc_barrier();
    rsp_delay = 25; rsp_value = 32'h0000_9000;
    issue(32'h0000_5000, 32'h4000_0000, 12'h0F0, 1'b1, 1'b1, 1'b0);
    wait_done("R6");
    check("R6 relocation count", 64'(n_rel), 64'd1);
    check("R6 old address sent", 64'(got_rel), 64'h0000_5000);
    check("R6 no mailbox", 64'(n_mbox), 64'd0);
    check("R6 writeback addr", 64'(got_wb_addr), 64'h4000_00F0);
    check("R6 writeback data", 64'(got_wb), 64'h0000_9000);
    check("R6 done value", 64'(got_done), 64'h0000_9000);
  endtask

  task automatic t_reloc_plain();
    rsp_delay = 3; rsp_value = 32'h0000_A000;
    issue(32'h0000_5500, 32'h4000_0000, 12'h004, 1'b1, 1'b0, 1'b1);
    wait_done("R7");
    check("R7 relocation count", 64'(n_rel), 64'd1);
    check("R7 no writeback", 64'(n_wb), 64'd0);
    check("R7 no mailbox", 64'(n_mbox), 64'd0);
    check("R7 register value", 64'(got_done), 64'h0000_A000);
    // Ordinary access with a stale tag and no fault: untouched.
    issue(32'h0000_5600, 32'h4000_0000, 12'h004, 1'b0, 1'b0, 1'b1);
    wait_done("R7");
    check("R7 stale plain no mailbox", 64'(n_mbox), 64'd0);
    check("R7 stale plain no writeback", 64'(n_wb), 64'd0);
    check("R7 stale plain value", 64'(got_done), 64'h0000_5600);
  endtask

  task automatic t_both();
    rsp_delay = 7; rsp_value = 32'h0000_B000;
    issue(32'h0000_6000, 32'h5000_0000, 12'h100, 1'b1, 1'b1, 1'b1);
    wait_done("R8");
    check("R8 relocation old addr", 64'(got_rel), 64'h0000_6000);
    check("R8 mailbox gets new addr", 64'(got_mbox), 64'h0000_B000);
    check("R8 mailbox count", 64'(n_mbox), 64'd1);
    check("R8 writeback data", 64'(got_wb), 64'h8000_B000);
    check("R8 writeback addr", 64'(got_wb_addr), 64'h5000_0100);
  endtask

  initial begin
    clear_counts();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean(1'b0, 32'h0000_1000);
    t_clean(1'b1, 32'h8000_2000);
    t_stale("R3", 1'b1, 32'h0000_3000);
    t_stale("R9 parity0", 1'b0, 32'h8000_4000);
    // R9: the same reference is clean under the other parity.
    t_clean(1'b1, 32'h8000_4000);
    t_stall();
    t_reloc_barrier();
    t_reloc_plain();
    t_both();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule